// File: doc/BRIEF.md
# Wide Register Dword Access Collector

This block sits between a 32-bit host port and a small bank of 128-bit control/status registers plus a bank of 64-bit memory words. The host moves only one dword per access, so the block makes each wide access appear atomic. On a read it snapshots the whole wide value once. Later dword reads of that same word come from the snapshot. On a write it gathers dwords in a single shared collector and updates the target only when the word is complete. At that point it emits a one-cycle commit strobe that carries the full value.

Two write-only descriptor-pointer registers have a shortcut. A write to their top dword always commits, and any low dword the collector does not hold is committed as zero. A timer-command register flushes the collector when its dword 0 is written. A read-to-clear status register collects event bits. Those bits are cleared when a read snapshots the register.

Top module: `wrc_bridge`

## Requirements
- R1: The dword address is {region, index, lane}. Region 0 selects a CSR: bits [4:2] give the index and bits [1:0] the lane, with 4 lanes per CSR. Region 1 (bit 5) selects a memory word: bits [4:1] give the word and bit 0 the lane, with 2 lanes per word. The CSR indices are: control 0, auxiliary 1, status 2, RX pointer 3, TX pointer 4, timer command 5. The commit key is {region, index}, so CSRs use keys 0..7 and memory word w uses key 16+w.
- R2: A read pulse on rd_i produces rvalid_o with its data in the next cycle, and rvalid_o is low at all other times.
- R3: A read of lane 0, or of a word other than the one in the snapshot, copies that word's whole live value into the snapshot. Any other read lane returns snapshot data, even if the word has been changed since.
- R4: An ordinary CSR write is held in the collector and commits only when all four lanes are held, in any order. The commit updates the register and pulses wr_stb_o for one cycle, one cycle after the final write, with wr_key_o and the 128-bit wr_data_o. ctrl_o changes only on such a commit.
- R5: A memory word commits after both of its lanes are written. The strobe carries the value zero-extended to 128 bits, and reads of the word follow R3.
- R6: While the collector holds lanes for one target, a non-committing write to any other target is discarded. The collector keeps its contents.
- R7: Reads of the pointer and timer registers return zero, and they leave the snapshot unchanged.
- R8: A write to lane 3 of a pointer register always commits it. Lanes 0..2 come from the collector if it holds that pointer, and are zero otherwise. The collector empties only if it held that pointer. A write to any other pointer lane is collected as in R4 and R6.
- R9: A write to lane 0 of the timer register empties the collector and strobes {96'b0, wdata}. Writes to its other lanes have no effect.
- R10: Status bits are set by stat_set_i. They clear when a read copies the status register into the snapshot, and a set in that same cycle wins. Reads served from the snapshot clear nothing. Status writes are ignored.
- R11: After reset, every register, output and memory word is zero, the collector is empty and the snapshot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Host dword read request |
| wr_i | input | 1 | Host dword write request |
| addr_i | input | 6 | Host dword address |
| wdata_i | input | 32 | Host write data |
| stat_set_i | input | 64 | Status event bits to set |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| wr_stb_o | output | 1 | Commit strobe |
| wr_key_o | output | 5 | Key of committed word |
| wr_data_o | output | 128 | Committed wide value |
| ctrl_o | output | 128 | Current control register value |

## Verification
The checker assumes that addr_i and wdata_i are defined whenever rd_i or wr_i is high. It also assumes that host inputs change only between clock edges. Its pointer and timer decode reads the address bits directly, so it relies on the address layout in R1. The bench drives every input on the falling edge and issues each access as a separate one-cycle pulse. It uses only addresses inside the decoded map, which keeps the stimulus within those assumptions.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned LANES     = 4;
  localparam int unsigned WIDE_W    = DW * LANES;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_AUX   = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_RXPTR = 3;
  localparam int unsigned IDX_TXPTR = 4;
  localparam int unsigned IDX_TIMER = 5;

  typedef enum logic [2:0] {
    K_NONE, K_PLAIN, K_STAT, K_PTR, K_TIMER
  } kind_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode import wrc_pkg::*; #(
  parameter int unsigned CSR_AW = 3,
  parameter int unsigned MEM_AW = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned KEY_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [1:0]        lane_o,
  output logic              is_mem_o,
  output kind_e             kind_o
);
  localparam int unsigned IW = KEY_W - 1;
  logic [IW-1:0] idx;

  always_comb begin
    is_mem_o = addr_i[ADDR_W-1];
    idx      = '0;
    lane_o   = '0;
    kind_o   = K_NONE;
    if (is_mem_o) begin
      idx[MEM_AW-1:0] = addr_i[MEM_AW:1];
      lane_o          = {1'b0, addr_i[0]};
      kind_o          = K_PLAIN;
    end else begin
      idx[CSR_AW-1:0] = addr_i[CSR_AW+1:2];
      lane_o          = addr_i[1:0];
      if (idx == IW'(IDX_CTRL) || idx == IW'(IDX_AUX))        kind_o = K_PLAIN;
      else if (idx == IW'(IDX_STAT))                         kind_o = K_STAT;
      else if (idx == IW'(IDX_RXPTR) || idx == IW'(IDX_TXPTR)) kind_o = K_PTR;
      else if (idx == IW'(IDX_TIMER))                        kind_o = K_TIMER;
    end
    key_o = {is_mem_o, idx};
  end
endmodule

// File: rtl/wrc_collect.sv
module wrc_collect import wrc_pkg::*; #(
  parameter int unsigned KEY_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [1:0]        lane_i,
  input  logic              is_mem_i,
  input  kind_e             kind_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              commit_o,
  output logic [WIDE_W-1:0] commit_data_o,
  output logic [LANES-1:0]  mask_o
);
  logic [KEY_W-1:0]  tgt_q;
  logic [LANES-1:0]  mask_q, mask_n, lane_bit, full_mask;
  logic [WIDE_W-1:0] data_q, merged, ptr_data;
  logic              own, hit, clr, store;

  always_comb begin
    lane_bit  = LANES'(1) << lane_i;
    full_mask = is_mem_i ? LANES'(3) : '1;
    own       = (mask_q != '0) && (tgt_q == key_i);
    hit       = (mask_q == '0) || own;
    mask_n    = mask_q | lane_bit;
    merged    = data_q;
    merged[lane_i*DW +: DW] = wdata_i;
    // pointer commit: keep only lanes this pointer already owns
    for (int l = 0; l < LANES-1; l++)
      ptr_data[l*DW +: DW] = (own && mask_q[l]) ? data_q[l*DW +: DW] : '0;
    ptr_data[WIDE_W-1 -: DW] = wdata_i;
    commit_o      = 1'b0;
    commit_data_o = merged;
    clr           = 1'b0;
    store         = 1'b0;
    if (we_i) begin
      case (kind_i)
        K_PLAIN: if (hit) begin
          if (mask_n == full_mask) begin commit_o = 1'b1; clr = 1'b1; end
          else store = 1'b1;
        end
        K_PTR: if (lane_i == 2'd3) begin
          commit_o = 1'b1; commit_data_o = ptr_data; clr = own;
        end else if (hit) store = 1'b1;
        K_TIMER: if (lane_i == 2'd0) begin
          commit_o = 1'b1; commit_data_o = {{(WIDE_W-DW){1'b0}}, wdata_i}; clr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (store) begin
      mask_q <= mask_n;
      tgt_q  <= key_i;
      data_q <= merged;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/wrc_rdlatch.sv
module wrc_rdlatch import wrc_pkg::*; #(
  parameter int unsigned KEY_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [1:0]        lane_i,
  input  kind_e             kind_i,
  input  logic [WIDE_W-1:0] live_i,
  output logic              take_o,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o
);
  logic [KEY_W-1:0]  lkey_q;
  logic              lvalid_q, readable;
  logic [WIDE_W-1:0] ldata_q, src;

  always_comb begin
    readable = (kind_i == K_PLAIN) || (kind_i == K_STAT);
    take_o   = rd_i && readable && (lane_i == 2'd0 || !lvalid_q || lkey_q != key_i);
    src      = take_o ? live_i : ldata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkey_q   <= '0;
      lvalid_q <= 1'b0;
      ldata_q  <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= readable ? src[lane_i*DW +: DW] : '0;
      if (take_o) begin
        lkey_q   <= key_i;
        lvalid_q <= 1'b1;
        ldata_q  <= live_i;
      end
    end
  end
endmodule

// File: rtl/wrc_bridge.sv
module wrc_bridge import wrc_pkg::*; #(
  parameter int unsigned CSR_AW = 3,
  parameter int unsigned MEM_AW = 4,
  parameter int unsigned STAT_W = 64,
  localparam int unsigned ADDR_W = 1 + ((CSR_AW + 2 > MEM_AW + 1) ? CSR_AW + 2 : MEM_AW + 1),
  localparam int unsigned KEY_W  = 1 + ((CSR_AW > MEM_AW) ? CSR_AW : MEM_AW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [STAT_W-1:0] stat_set_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              wr_stb_o,
  output logic [KEY_W-1:0]  wr_key_o,
  output logic [WIDE_W-1:0] wr_data_o,
  output logic [WIDE_W-1:0] ctrl_o
);
  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;
  localparam int unsigned MEM_W     = 2 * DW;

  logic [KEY_W-1:0]  key;
  logic [1:0]        lane;
  logic              is_mem, commit, take;
  kind_e             kind;
  logic [WIDE_W-1:0] commit_data, live, ctrl_q, aux_q;
  logic [LANES-1:0]  col_mask;
  logic [STAT_W-1:0] stat_q;
  logic [MEM_W-1:0]  mem_q [MEM_DEPTH];

  wrc_decode #(.CSR_AW(CSR_AW), .MEM_AW(MEM_AW), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) i_dec (
    .addr_i(addr_i), .key_o(key), .lane_o(lane), .is_mem_o(is_mem), .kind_o(kind)
  );

  wrc_collect #(.KEY_W(KEY_W)) i_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i), .key_i(key), .lane_i(lane),
    .is_mem_i(is_mem), .kind_i(kind), .wdata_i(wdata_i), .commit_o(commit),
    .commit_data_o(commit_data), .mask_o(col_mask)
  );

  wrc_rdlatch #(.KEY_W(KEY_W)) i_rdl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .key_i(key), .lane_i(lane),
    .kind_i(kind), .live_i(live), .take_o(take), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  always_comb begin
    live = '0;
    if (is_mem)                         live[MEM_W-1:0]  = mem_q[key[MEM_AW-1:0]];
    else if (key == KEY_W'(IDX_CTRL))   live             = ctrl_q;
    else if (key == KEY_W'(IDX_AUX))    live             = aux_q;
    else if (key == KEY_W'(IDX_STAT))   live[STAT_W-1:0] = stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      aux_q     <= '0;
      stat_q    <= '0;
      wr_stb_o  <= 1'b0;
      wr_key_o  <= '0;
      wr_data_o <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else begin
      // clear on snapshot, new events win
      stat_q   <= ((take && kind == K_STAT) ? '0 : stat_q) | stat_set_i;
      wr_stb_o <= commit;
      if (commit) begin
        wr_key_o  <= key;
        wr_data_o <= is_mem ? {{(WIDE_W-MEM_W){1'b0}}, commit_data[MEM_W-1:0]} : commit_data;
        if (is_mem)                        mem_q[key[MEM_AW-1:0]] <= commit_data[MEM_W-1:0];
        else if (key == KEY_W'(IDX_CTRL))  ctrl_q <= commit_data;
        else if (key == KEY_W'(IDX_AUX))   aux_q  <= commit_data;
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wrc_bridge_chk.sv
module wrc_bridge_chk import wrc_pkg::*; #(
  parameter int unsigned CSR_AW = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned KEY_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              rvalid_o,
  input logic [DW-1:0]     rdata_o,
  input logic              wr_stb_o,
  input logic [KEY_W-1:0]  wr_key_o,
  input logic [WIDE_W-1:0] wr_data_o,
  input logic [WIDE_W-1:0] ctrl_o,
  input logic [LANES-1:0]  col_mask
);
  logic              csr_sel, ptr_sel, tmr_sel;
  logic [CSR_AW-1:0] cidx;
  logic [1:0]        clane;

  always_comb begin
    csr_sel = !addr_i[ADDR_W-1];
    cidx    = addr_i[CSR_AW+1:2];
    clane   = addr_i[1:0];
    ptr_sel = csr_sel && (cidx == CSR_AW'(IDX_RXPTR) || cidx == CSR_AW'(IDX_TXPTR));
    tmr_sel = csr_sel && (cidx == CSR_AW'(IDX_TIMER));
  end

  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r2_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  a_r7_ptr_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ptr_sel) |=> (rdata_o == '0));
  a_r8_ptr_top_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ptr_sel && clane == 2'd3) |=> (wr_stb_o && wr_data_o[WIDE_W-1 -: DW] == $past(wdata_i)));
  a_r9_timer_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tmr_sel && clane == 2'd0) |=> (col_mask == '0 && wr_stb_o && wr_data_o[WIDE_W-1:DW] == '0));
  a_r4_ctrl_atomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> (wr_stb_o && wr_key_o == KEY_W'(IDX_CTRL)));
  a_r4_stb_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(wr_i));
endmodule

bind wrc_bridge wrc_bridge_chk #(.CSR_AW(CSR_AW), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .wr_stb_o(wr_stb_o),
  .wr_key_o(wr_key_o), .wr_data_o(wr_data_o), .ctrl_o(ctrl_o), .col_mask(col_mask)
);

// File: tb/test_wrc_bridge.sv
`timescale 1ns/1ps
module test_wrc_bridge;
  logic         clk_i = 1'b0, rst_ni = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [5:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [63:0]  stat_set_i = '0;
  logic         rvalid_o, wr_stb_o;
  logic [31:0]  rdata_o;
  logic [4:0]   wr_key_o;
  logic [127:0] wr_data_o, ctrl_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wrc_bridge i_wrc_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .stat_set_i(stat_set_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .wr_stb_o(wr_stb_o), .wr_key_o(wr_key_o), .wr_data_o(wr_data_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [5:0] csr(input int idx, input int lane);
    return {1'b0, 3'(idx), 2'(lane)};
  endfunction
  function automatic logic [5:0] mem(input int word, input int lane);
    return {1'b1, 4'(word), 1'(lane)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic wr_full(input int idx, input logic [127:0] v);
    for (int l = 0; l < 4; l++) wr(csr(idx, l), v[l*32 +: 32]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 rvalid", rvalid_o, 0);
    chk("R11 stb", wr_stb_o, 0);
    chk("R11 ctrl", ctrl_o, 0);
    rd(csr(0, 0), d);
    chk("R11 ctrl read", d, 0);
    chk("R2 rvalid after read", rvalid_o, 1);
    @(negedge clk_i);
    chk("R2 rvalid drops", rvalid_o, 0);
  endtask

  task automatic t_plain_commit();
    logic [127:0] v = 128'h44444444_33333333_22222222_11111111;
    wr(csr(0, 2), v[95:64]);  chk("R4 no commit lane2", wr_stb_o, 0);
    wr(csr(0, 0), v[31:0]);   chk("R4 no commit lane0", wr_stb_o, 0);
    wr(csr(0, 3), v[127:96]); chk("R4 no commit lane3", wr_stb_o, 0);
    chk("R4 ctrl held", ctrl_o, 0);
    wr(csr(0, 1), v[63:32]);
    chk("R4 commit strobe", wr_stb_o, 1);
    chk("R4 R1 commit key", wr_key_o, 0);
    chk("R4 commit data", wr_data_o, v);
    chk("R4 ctrl updated", ctrl_o, v);
    @(negedge clk_i);
    chk("R4 strobe one cycle", wr_stb_o, 0);
  endtask

  task automatic t_latch();
    logic [127:0] a = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
    logic [127:0] b = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
    logic [31:0] d;
    wr_full(1, a);
    rd(csr(1, 0), d); chk("R3 lane0 live", d, a[31:0]);
    wr_full(1, b);
    rd(csr(1, 2), d); chk("R3 lane2 from snapshot", d, a[95:64]);
    rd(csr(0, 1), d); chk("R3 other word latches", d, ctrl_o[63:32]);
    rd(csr(1, 3), d); chk("R3 return relatches", d, b[127:96]);
    rd(csr(1, 0), d); chk("R3 lane0 relatch", d, b[31:0]);
  endtask

  task automatic t_mem();
    logic [31:0] d;
    wr(mem(5, 1), 32'hCAFE0001); chk("R5 half word held", wr_stb_o, 0);
    wr(mem(5, 0), 32'hCAFE0000);
    chk("R5 commit strobe", wr_stb_o, 1);
    chk("R5 R1 mem key", wr_key_o, 5'd21);
    chk("R5 zero-extended", wr_data_o, {64'h0, 32'hCAFE0001, 32'hCAFE0000});
    rd(mem(5, 1), d); chk("R5 read hi", d, 32'hCAFE0001);
    rd(mem(5, 0), d); chk("R5 read lo", d, 32'hCAFE0000);
    wr(mem(15, 0), 32'h0F0F0F0F);
    wr(mem(15, 1), 32'hF0F0F0F0);
    chk("R5 R1 last word key", wr_key_o, 5'd31);
    rd(mem(15, 0), d); chk("R5 last word lo", d, 32'h0F0F0F0F);
  endtask

  task automatic t_foreign();
    logic [31:0] d;
    logic [127:0] b = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
    wr(csr(0, 0), 32'h5A5A0000);
    wr_full(1, 128'hDEAD0003_DEAD0002_DEAD0001_DEAD0000);
    chk("R6 foreign full word no commit", wr_stb_o, 0);
    rd(csr(1, 0), d); chk("R6 aux unchanged", d, b[31:0]);
    wr(csr(0, 3), 32'h5A5A0003);
    wr(csr(0, 2), 32'h5A5A0002);
    wr(csr(0, 1), 32'h5A5A0001);
    chk("R6 held target completes", wr_data_o, 128'h5A5A0003_5A5A0002_5A5A0001_5A5A0000);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    wr(csr(3, 3), 32'h11110003);
    chk("R8 empty collector strobe", wr_stb_o, 1);
    chk("R8 R1 rx key", wr_key_o, 5'd3);
    chk("R8 zero fill", wr_data_o, {32'h11110003, 96'h0});
    wr(csr(3, 0), 32'h22220000);
    wr(csr(3, 1), 32'h22220001);
    chk("R8 low lanes held", wr_stb_o, 0);
    wr(csr(3, 3), 32'h22220003);
    chk("R8 held lanes merged", wr_data_o, {32'h22220003, 32'h0, 32'h22220001, 32'h22220000});
    wr(csr(3, 3), 32'h33330003);
    chk("R8 collector emptied", wr_data_o, {32'h33330003, 96'h0});
    wr(csr(0, 0), 32'h77770000);
    wr(csr(4, 1), 32'h44440001);
    chk("R6 foreign ptr lane dropped", wr_stb_o, 0);
    wr(csr(4, 3), 32'h44440003);
    chk("R8 R1 tx key", wr_key_o, 5'd4);
    chk("R8 foreign held gives zeros", wr_data_o, {32'h44440003, 96'h0});
    wr(csr(0, 1), 32'h77770001);
    wr(csr(0, 2), 32'h77770002);
    wr(csr(0, 3), 32'h77770003);
    chk("R8 other target kept", ctrl_o, 128'h77770003_77770002_77770001_77770000);
    // R7: pointer reads give zero and leave snapshot
    rd(csr(1, 0), d);
    wr_full(1, 128'h99990003_99990002_99990001_99990000);
    rd(csr(3, 1), d); chk("R7 rx read zero", d, 0);
    rd(csr(4, 0), d); chk("R7 tx read zero", d, 0);
    rd(csr(5, 0), d); chk("R7 timer read zero", d, 0);
    rd(csr(1, 2), d); chk("R7 snapshot kept", d, 32'hB2B2B2B2);
  endtask

  task automatic t_timer();
    logic [127:0] c0 = ctrl_o;
    wr(csr(0, 0), 32'hAAAA0000);
    wr(csr(0, 1), 32'hAAAA0001);
    wr(csr(5, 0), 32'h12345678);
    chk("R9 timer strobe", wr_stb_o, 1);
    chk("R9 R1 timer key", wr_key_o, 5'd5);
    chk("R9 timer data", wr_data_o, {96'h0, 32'h12345678});
    wr(csr(0, 2), 32'hBBBB0002);
    wr(csr(0, 3), 32'hBBBB0003);
    chk("R9 flushed lanes lost", wr_stb_o, 0);
    chk("R9 ctrl unchanged", ctrl_o, c0);
    wr(csr(5, 1), 32'hFFFFFFFF);
    chk("R9 upper timer lane ignored", wr_stb_o, 0);
    wr(csr(0, 0), 32'hCCCC0000);
    wr(csr(0, 1), 32'hCCCC0001);
    chk("R9 collector survived lane1", ctrl_o, 128'hBBBB0003_BBBB0002_CCCC0001_CCCC0000);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk_i); stat_set_i = 64'h80000001_00000010;
    @(negedge clk_i); stat_set_i = '0;
    wr(csr(2, 0), 32'hFFFFFFFF); wr(csr(2, 1), 32'hFFFFFFFF);
    wr(csr(2, 2), 32'hFFFFFFFF); wr(csr(2, 3), 32'hFFFFFFFF);
    chk("R10 status write ignored", wr_stb_o, 0);
    rd(csr(2, 0), d); chk("R10 status lo", d, 32'h00000010);
    rd(csr(2, 1), d); chk("R10 status hi from snapshot", d, 32'h80000001);
    rd(csr(2, 0), d); chk("R10 cleared on latch", d, 0);
    @(negedge clk_i); rd_i = 1'b1; addr_i = csr(2, 0); stat_set_i = 64'h4;
    @(negedge clk_i); rd_i = 1'b0; stat_set_i = '0; d = rdata_o;
    chk("R10 read before set", d, 0);
    rd(csr(2, 1), d); chk("R10 snapshot read", d, 0);
    rd(csr(2, 0), d); chk("R10 set wins over clear", d, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_pre: begin
      chk("R11 stb in reset", wr_stb_o, 0);
    end
    rst_ni = 1'b1;
    t_reset();
    t_plain_commit();
    t_latch();
    t_mem();
    t_foreign();
    t_ptr();
    t_timer();
    t_status();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule